// File: doc/BRIEF.md
# Glitch-tolerant cartridge read responder

This block makes on-chip memory appear as a plain read-only device on a console cartridge slot. It watches the slot's active-low chip-enable and output-enable strobes and its address lines, all of them inputs only. When a read cycle opens it asks a memory controller for one word over a request/acknowledge handshake. It keeps the returned word in a register and presents it to the data pads, together with a drive-enable that controls the external tri-state buffer.

The strobes on such a slot can carry short spurious pulses. A brief high pulse on output-enable in the middle of a read must not start a second fetch or push the cycle logic out of step. Both strobes are therefore synchronised. A cycle is closed only after output-enable has stayed inactive for a programmable run of consecutive clocks. The pads are driven only while both strobes are active.

Top module: `cart_read_responder`

## Requirements
- R1: After reset, `mem_req` and `bus_data_oe` are low and the block waits for a read cycle.
- R2: A fetch starts only from the waiting state, when the synchronised output-enable falls while the synchronised chip-enable is low. `mem_req` then rises with `mem_addr` equal to `bus_addr` at that moment, and `mem_addr` holds until the acknowledge.
- R3: `mem_req` stays high until a cycle with `mem_ack` high and is low in the following cycle; exactly one request is issued per read cycle.
- R4: The word on `bus_data_o` is the `mem_rdata` value captured in the acknowledge cycle. Later changes of `mem_rdata` do not alter it.
- R5: `bus_data_oe` is high only when a captured word is held and both synchronised strobes are low. It never rises while chip-enable has been high for the past two clocks.
- R6: After `bus_oe_n` rises, `bus_data_oe` is low by the second rising clock edge.
- R7: A cycle closes only after synchronised output-enable has been high for QUIET_CYCLES (default 4) consecutive clocks. High pulses of 1, 2 or 3 clocks leave the cycle open: no new request is issued, and the word is driven again when output-enable returns low. A pulse of 4 clocks closes the cycle, so the next fall opens a new fetch.
- R8: If output-enable rises before the acknowledge, the request is still held until `mem_ack`. The block then closes the cycle without driving, and the next read works normally.
- R9: Output-enable activity while chip-enable is high issues no request and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Slot chip-enable, active low, asynchronous |
| bus_oe_n | input | 1 | Slot output-enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Slot word address, never driven |
| bus_data_o | output | DATA_W | Registered word for the data pads |
| bus_data_oe | output | 1 | Drive-enable of the data pad buffer |
| mem_req | output | 1 | Fetch request to the memory controller |
| mem_addr | output | ADDR_W | Word address of the fetch |
| mem_ack | input | 1 | Controller acknowledge, data valid this cycle |
| mem_rdata | input | DATA_W | Controller read data |

## Verification
The assertions assume that the controller raises `mem_ack` only while `mem_req` is high, for a single cycle. They also assume that `bus_addr` is stable from the chip-enable fall until output-enable rises. The drive check assumes the default synchroniser depth of two flops. The bench memory model acknowledges one cycle-pulse per request after a chosen delay and scrambles its read data afterwards. The bus driver sets the address a cycle before it lowers output-enable and holds it until chip-enable is released.

// File: rtl/cart_rd_pkg.sv
package cart_rd_pkg;

  typedef enum logic [1:0] {
    CYC_WAIT  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_HOLD  = 2'd2
  } cyc_state_e;

  // a read opens when the output strobe goes from inactive to active with chip selected
  function automatic logic open_cycle(input logic oe_was_off, input logic oe_on,
                                      input logic ce_on);
    return oe_was_off && oe_on && ce_on;
  endfunction

  // the quiet run is complete when this clock's inactive sample reaches the limit
  function automatic logic quiet_reached(input int unsigned seen, input logic off_now,
                                         input int unsigned limit);
    return off_now && ((seen + 1) >= limit);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int   WIDTH  = 2,
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/quiet_window.sv
module quiet_window #(
  parameter int QUIET = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_off,
  output logic quiet_done
);
  import cart_rd_pkg::*;

  localparam int CW = $clog2(QUIET + 1);
  localparam logic [CW-1:0] SAT = CW'(QUIET - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= SAT;
    else if (!strobe_off) run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  assign quiet_done = quiet_reached(int'(run_q), strobe_off, QUIET);

endmodule

// File: rtl/rd_cycle_fsm.sv
module rd_cycle_fsm #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_req,
  input  logic              quiet_done,
  input  logic              ce_on,
  input  logic              oe_on,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] word_q,
  output logic              drive_en,
  output logic              cyc_idle
);
  import cart_rd_pkg::*;

  cyc_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CYC_WAIT;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      word_q   <= '0;
    end else begin
      unique case (state_q)
        CYC_WAIT: if (open_req) begin
          state_q  <= CYC_FETCH;
          mem_req  <= 1'b1;
          mem_addr <= bus_addr;
        end
        CYC_FETCH: if (mem_ack) begin
          state_q <= CYC_HOLD;
          mem_req <= 1'b0;
          word_q  <= mem_rdata;
        end
        CYC_HOLD: if (quiet_done) state_q <= CYC_WAIT;
        default: state_q <= CYC_WAIT;
      endcase
    end
  end

  assign cyc_idle = (state_q == CYC_WAIT);
  assign drive_en = (state_q == CYC_HOLD) && ce_on && oe_on;

endmodule

// File: rtl/cart_read_responder.sv
module cart_read_responder #(
  parameter int ADDR_W       = 23,
  parameter int DATA_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int QUIET_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import cart_rd_pkg::*;

  logic [1:0] strobes_s;
  logic       ce_off_s, oe_off_s, oe_off_prev;
  logic       open_req, quiet_done, cyc_idle;

  strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({bus_ce_n, bus_oe_n}),
    .sync_o(strobes_s)
  );
  assign ce_off_s = strobes_s[1];
  assign oe_off_s = strobes_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_off_prev <= 1'b1;
    else        oe_off_prev <= oe_off_s;
  end

  assign open_req = open_cycle(oe_off_prev, !oe_off_s, !ce_off_s);

  quiet_window #(.QUIET(QUIET_CYCLES)) u_quiet (
    .clk(clk), .rst_n(rst_n),
    .strobe_off(oe_off_s),
    .quiet_done(quiet_done)
  );

  rd_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .open_req(open_req), .quiet_done(quiet_done),
    .ce_on(!ce_off_s), .oe_on(!oe_off_s),
    .bus_addr(bus_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .word_q(bus_data_o), .drive_en(bus_data_oe),
    .cyc_idle(cyc_idle)
  );

endmodule

// File: rtl/cart_rd_checker.sv
module cart_rd_checker #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int QUIET  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ce_n,
  input logic              bus_oe_n,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_data_oe,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              oe_off_s,
  input logic              cyc_idle
);
  localparam int CW = $clog2(QUIET + 1);
  logic [CW-1:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          off_run <= '0;
    else if (!oe_off_s)  off_run <= '0;
    else if (off_run != CW'(QUIET)) off_run <= off_run + 1'b1;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr)); // R2
  AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(cyc_idle)); // R2
  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> !$past(bus_ce_n, 2) && !$past(bus_oe_n, 2)); // R5
  AST_NO_DRIVE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !bus_data_oe); // R4
  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe && $past(bus_data_oe) |-> $stable(bus_data_o)); // R4
  AST_IDLE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_idle) |-> off_run >= CW'(QUIET)); // R7

endmodule

bind cart_read_responder cart_rd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .QUIET(QUIET_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
  .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .oe_off_s(oe_off_s), .cyc_idle(cyc_idle)
);

// File: tb/sim_cart_read_responder.sv
`timescale 1ns/1ps
module sim_cart_read_responder;
  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce_n = 1'b1, bus_oe_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data_o;
  logic bus_data_oe, mem_req, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  int req_rises = 0;
  int ack_delay = 2;
  int wait_cnt = 0;
  bit finished = 0;
  bit pending = 0;
  logic req_prev = 1'b0;
  int ce_hi_run = 0;
  logic [AW-1:0] exp_addr_q[$];
  logic [DW-1:0] exp_data_q[$];

  always #5 clk = ~clk;

  cart_read_responder u0 (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_addr(bus_addr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h31};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory controller model: one-cycle ack after ack_delay, then scramble data (R4)
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      mem_rdata <= ~mem_rdata;
      wait_cnt = 0;
    end else if (mem_req) begin
      if (wait_cnt >= ack_delay) begin
        mem_ack <= 1'b1;
        mem_rdata <= word_of(mem_addr);
      end else wait_cnt++;
    end
  end

  // monitor: scoreboard pops on request rise (R2) and on first drive (R4); gating (R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && !req_prev) begin
        req_rises++;
        pending = 1;
        if (exp_addr_q.size() == 0)
          check(0, "R9", "unexpected request", mem_addr, 0);
        else begin
          logic [AW-1:0] ea;
          ea = exp_addr_q.pop_front();
          check(mem_addr == ea, "R2", "request address", mem_addr, ea);
        end
      end
      if (bus_data_oe && pending) begin
        pending = 0;
        if (exp_data_q.size() == 0)
          check(0, "R4", "unexpected drive", bus_data_o, 0);
        else begin
          logic [DW-1:0] ed;
          ed = exp_data_q.pop_front();
          check(bus_data_o == ed, "R4", "driven word", bus_data_o, ed);
        end
      end
      if (ce_hi_run >= 3)
        if (bus_data_oe) check(0, "R5", "drive with chip-enable high", 1, 0);
    end
    ce_hi_run = bus_ce_n ? ce_hi_run + 1 : 0;
    req_prev = mem_req;
  end

  task automatic ncyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // normal read with optional output-enable glitch of glen clocks
  task automatic do_read(input logic [AW-1:0] a, input int dly, input int glen);
    int base;
    ack_delay = dly;
    @(negedge clk); bus_addr = a; bus_ce_n = 1'b0;
    exp_addr_q.push_back(a); exp_data_q.push_back(word_of(a));
    base = req_rises;
    @(negedge clk); bus_oe_n = 1'b0;
    for (int i = 0; i < 40 && !bus_data_oe; i++) @(negedge clk);
    check(bus_data_oe == 1'b1, "R3", "drive after ack", bus_data_oe, 1);
    check(req_rises == base + 1, "R3", "one request", req_rises, base + 1);
    ncyc(3);
    check(bus_data_o == word_of(a), "R4", "word held after data change",
          bus_data_o, word_of(a));
    if (glen > 0) begin
      bus_oe_n = 1'b1;
      ncyc(glen);
      if (glen >= 4) begin
        exp_addr_q.push_back(a); exp_data_q.push_back(word_of(a));
      end
      bus_oe_n = 1'b0;
      ncyc(8 + dly);
      if (glen >= 4)
        check(req_rises == base + 2, "R7", "4-clock pulse reopens", req_rises, base + 2);
      else
        check(req_rises == base + 1, "R7", "short pulse ignored", req_rises, base + 1);
      check(bus_data_oe == 1'b1, "R7", "drive resumes after pulse", bus_data_oe, 1);
    end
    bus_oe_n = 1'b1;
    ncyc(2);
    check(bus_data_oe == 1'b0, "R6", "release after oe rise", bus_data_oe, 0);
    bus_ce_n = 1'b1;
    ncyc(6);
  endtask

  initial begin
    ncyc(4);
    check(mem_req == 1'b0, "R1", "req in reset", mem_req, 0);
    check(bus_data_oe == 1'b0, "R1", "oe in reset", bus_data_oe, 0);
    rst_n = 1'b1;
    ncyc(3);
    check(mem_req == 1'b0 && bus_data_oe == 1'b0, "R1", "idle after reset",
          {mem_req, bus_data_oe}, 0);

    do_read(23'h012345, 0, 0);
    do_read(23'h7FFFFF, 5, 0);
    do_read(23'h000000, 2, 1);
    do_read(23'h00A5F0, 1, 2);
    do_read(23'h03C3C3, 3, 3);
    do_read(23'h055AA1, 2, 4);

    // R8: output-enable released before the acknowledge
    begin
      int base;
      ack_delay = 10;
      base = req_rises;
      @(negedge clk); bus_addr = 23'h0BEEF0; bus_ce_n = 1'b0;
      exp_addr_q.push_back(23'h0BEEF0);
      @(negedge clk); bus_oe_n = 1'b0;
      ncyc(3); bus_oe_n = 1'b1;
      ncyc(4);
      check(mem_req == 1'b1, "R8", "request held until ack", mem_req, 1);
      ncyc(20);
      check(mem_req == 1'b0 && bus_data_oe == 1'b0, "R8", "closed without drive",
            {mem_req, bus_data_oe}, 0);
      check(req_rises == base + 1, "R8", "single request", req_rises, base + 1);
      pending = 0;
      bus_ce_n = 1'b1;
      ncyc(4);
    end
    do_read(23'h0BEEF2, 1, 0);

    // R9: output-enable toggles with chip-enable high
    begin
      int base;
      base = req_rises;
      @(negedge clk); bus_addr = 23'h001111; bus_ce_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
        bus_oe_n = 1'b0; ncyc(6);
        bus_oe_n = 1'b1; ncyc(6);
      end
      check(req_rises == base, "R9", "no request with ce high", req_rises, base);
      check(bus_data_oe == 1'b0, "R9", "no drive with ce high", bus_data_oe, 0);
    end

    check(exp_data_q.size() == 0, "R4", "all words delivered", exp_data_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ncyc(100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule